// File: doc/BRIEF.md
# Significance-Preserving Radix-16 Floating Adder

This unit adds or subtracts two 68-bit floating words and returns a result whose coefficient is never shifted left at the end. Each word carries a 3-bit tag, a sign, a 56-bit coefficient and an 8-bit biased exponent that counts powers of sixteen. Because there is no final left normalization, a difference of nearly equal numbers keeps its leading zero digits. The coefficient therefore shows how much significance the operation actually retained.

The tags do not take part in the arithmetic. The first operand's tag is held beside the pipeline, and the three bit positions it frees become overflow guard bits above the integer field. Operations enter through a one-cycle `start` strobe. A new operation may enter on every cycle, and each one leaves as a one-cycle `done` pulse three clock edges later.

Top module: `sigfloat_adder`

## Requirements
- R1: Word layout, MSB to LSB: tag [67:65], sign [64], coefficient [63:8] (integer digit [63:60], fraction [59:8]), exponent [7:0]. The value is (-1)^sign × coefficient/2^52 × 16^(exponent − bias).
- R2: The operand with the smaller exponent has its coefficient shifted right by 4 bits for each unit of exponent difference, and the bits shifted out are dropped. The result takes the larger exponent. At a difference of 14 or more, that operand contributes zero.
- R3: The result is never shifted left, so leading zero digits of the coefficient are kept.
- R4: If the combined magnitude reaches 16 or more, the coefficient shifts right by 4 bits, its low 4 bits are dropped, and the exponent increments.
- R5: If R4 applies and the exponent is already 255, `ovf` is 1, the exponent stays 255 and the coefficient is still shifted. Otherwise `ovf` is 0.
- R6: With `op_sub`=1 the sign of the second operand is inverted before combining.
- R7: Operands with the same effective sign add their magnitudes and keep that sign. Operands with different signs subtract the smaller magnitude from the larger and take the sign of the larger. A zero magnitude always gets sign 0.
- R8: `tag_out` and result bits [67:65] equal the first operand's tag. The second operand's tag has no effect on any output.
- R9: `done` is high for exactly one cycle, on the third rising edge counting the edge that samples `start`. Operations may be started on consecutive cycles.
- R10: After synchronous reset, `result`, `tag_out`, `ovf` and `done` are all zero.
- R11: `result`, `tag_out` and `ovf` change only on the edge that raises `done`, and hold their values otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept an operation this cycle |
| op_sub | input | 1 | 1 = subtract `opnd_b` from `opnd_a` |
| opnd_a | input | 68 | First operand word |
| opnd_b | input | 68 | Second operand word |
| result | output | 68 | Result word, tag restored on top |
| tag_out | output | 3 | Saved tag of the first operand |
| ovf | output | 1 | Exponent overflow on carry renormalization |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench subtracts nearly equal values and checks that the result still has leading zero digits; a design that left-normalized would return a larger coefficient with a lower exponent. It drives exponent differences of 13 and 14, and operands where the second one has the larger exponent. These cases catch an alignment shift that uses the wrong digit width, wraps around, or moves the wrong operand. Carry-out at exponent 255, sums whose dropped low bits are nonzero, and exact cancellation are all driven. These catch a wrapping exponent, rounding in place of truncation, and a negative zero. The bench issues operations back to back with differing second-operand tags, which catches a pipeline that mixes up operations or takes the tag from the second operand.

// File: rtl/sfadd_pkg.sv
package sfadd_pkg;
  parameter int TAG_W   = 3;
  parameter int INT_W   = 4;
  parameter int FRAC_W  = 52;
  parameter int EXP_W   = 8;
  parameter int DIGIT_W = 4;

  localparam int COEF_W   = INT_W + FRAC_W;
  localparam int GUARD_W  = TAG_W;
  localparam int MAG_W    = COEF_W + GUARD_W;
  localparam int WORD_W   = TAG_W + 1 + COEF_W + EXP_W;
  localparam int SPAN_DIG = COEF_W / DIGIT_W;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic              sign;
    logic [COEF_W-1:0] coef;
    logic [EXP_W-1:0]  expo;
  } word_t;

  typedef struct packed {
    logic              vld;
    logic [TAG_W-1:0]  tag;
    logic              sx;
    logic              sy;
    logic [MAG_W-1:0]  mx;
    logic [MAG_W-1:0]  my;
    logic [EXP_W-1:0]  expo;
  } aligned_t;

  typedef struct packed {
    logic              vld;
    logic [TAG_W-1:0]  tag;
    logic              sign;
    logic [MAG_W-1:0]  mag;
    logic [EXP_W-1:0]  expo;
  } sum_t;
endpackage

// File: rtl/sfadd_align.sv
module sfadd_align
  import sfadd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     op_sub,
  input  word_t    a,
  input  word_t    b,
  output aligned_t q
);
  logic             a_big;
  logic             b_sign_eff;
  logic [EXP_W-1:0] diff;
  logic [MAG_W-1:0] small_mag;
  logic [MAG_W-1:0] small_shf;
  aligned_t         nxt;

  always_comb begin
    a_big      = (a.expo >= b.expo);
    b_sign_eff = b.sign ^ op_sub;
    diff       = a_big ? (a.expo - b.expo) : (b.expo - a.expo);
    small_mag  = a_big ? {{GUARD_W{1'b0}}, b.coef} : {{GUARD_W{1'b0}}, a.coef};
    if (diff >= EXP_W'(SPAN_DIG))
      small_shf = '0;
    else
      small_shf = small_mag >> (int'(diff) * DIGIT_W);
    nxt.vld  = start;
    nxt.tag  = a.tag;
    nxt.sx   = a_big ? a.sign : b_sign_eff;
    nxt.sy   = a_big ? b_sign_eff : a.sign;
    nxt.mx   = a_big ? {{GUARD_W{1'b0}}, a.coef} : {{GUARD_W{1'b0}}, b.coef};
    nxt.my   = small_shf;
    nxt.expo = a_big ? a.expo : b.expo;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/sfadd_combine.sv
module sfadd_combine
  import sfadd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  aligned_t d,
  output sum_t     q
);
  sum_t nxt;

  always_comb begin
    nxt.vld  = d.vld;
    nxt.tag  = d.tag;
    nxt.expo = d.expo;
    if (d.sx == d.sy) begin
      nxt.mag  = d.mx + d.my;
      nxt.sign = d.sx;
    end else if (d.mx >= d.my) begin
      nxt.mag  = d.mx - d.my;
      nxt.sign = d.sx;
    end else begin
      nxt.mag  = d.my - d.mx;
      nxt.sign = d.sy;
    end
    if (nxt.mag == '0) nxt.sign = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/sfadd_renorm.sv
module sfadd_renorm
  import sfadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  sum_t              d,
  output logic [WORD_W-1:0] result,
  output logic [TAG_W-1:0]  tag_out,
  output logic              ovf,
  output logic              done
);
  logic              carry;
  logic              top_exp;
  logic [MAG_W-1:0]  shf;
  word_t             w;

  always_comb begin
    carry   = |d.mag[MAG_W-1:COEF_W];
    top_exp = &d.expo;
    shf     = d.mag >> DIGIT_W;
    w.tag   = d.tag;
    w.sign  = d.sign;
    w.coef  = carry ? shf[COEF_W-1:0] : d.mag[COEF_W-1:0];
    w.expo  = (carry && !top_exp) ? d.expo + 1'b1 : d.expo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      tag_out <= '0;
      ovf     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= d.vld;
      if (d.vld) begin
        result  <= w;
        tag_out <= d.tag;
        ovf     <= carry && top_exp;
      end
    end
  end
endmodule

// File: rtl/sigfloat_adder.sv
module sigfloat_adder
  import sfadd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_sub,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  output logic [WORD_W-1:0] result,
  output logic [TAG_W-1:0]  tag_out,
  output logic              ovf,
  output logic              done
);
  aligned_t st1;
  sum_t     st2;

  sfadd_align u_align (
    .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
    .a(word_t'(opnd_a)), .b(word_t'(opnd_b)), .q(st1)
  );

  sfadd_combine u_comb (
    .clk(clk), .rst(rst), .d(st1), .q(st2)
  );

  sfadd_renorm u_renorm (
    .clk(clk), .rst(rst), .d(st2),
    .result(result), .tag_out(tag_out), .ovf(ovf), .done(done)
  );
endmodule

// File: rtl/sfadd_props.sv
module sfadd_props
  import sfadd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [WORD_W-1:0] opnd_a,
  input logic [WORD_W-1:0] result,
  input logic [TAG_W-1:0]  tag_out,
  input logic              ovf,
  input logic              done
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_done_latency_R9: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3) |-> (done == $past(start, 3)));

  assert_tag_first_R8: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && done) |-> (tag_out == $past(opnd_a[WORD_W-1 -: TAG_W], 3)));

  assert_ovf_exp_R5: assert property (@(posedge clk) disable iff (rst)
    (done && ovf) |-> (result[EXP_W-1:0] == {EXP_W{1'b1}}));

  assert_pos_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (done && result[EXP_W +: COEF_W] == '0) |-> !result[EXP_W + COEF_W]);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && !done) |-> ($stable(result) && $stable(ovf) && $stable(tag_out)));
endmodule

bind sigfloat_adder sfadd_props u_props (
  .clk(clk), .rst(rst), .start(start), .opnd_a(opnd_a),
  .result(result), .tag_out(tag_out), .ovf(ovf), .done(done)
);

// File: tb/sim_sigfloat_adder.sv
module sim_sigfloat_adder;
  import sfadd_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              op_sub = 1'b0;
  logic [WORD_W-1:0] opnd_a = '0;
  logic [WORD_W-1:0] opnd_b = '0;
  logic [WORD_W-1:0] result;
  logic [TAG_W-1:0]  tag_out;
  logic              ovf;
  logic              done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic run = 1'b0;

  typedef struct {
    logic [WORD_W-1:0] w;
    logic              ovf;
    int                cyc;
    string             req;
  } exp_t;
  exp_t sb[$];

  sigfloat_adder u0 (
    .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .tag_out(tag_out), .ovf(ovf), .done(done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [WORD_W-1:0] mk(input logic [2:0] t, input logic s,
                                            input logic [COEF_W-1:0] c, input logic [7:0] e);
    return {t, s, c, e};
  endfunction

  function automatic logic [COEF_W-1:0] dig(input int ip, input int pos);
    return COEF_W'(ip) << pos;
  endfunction

  function automatic exp_t model(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                                 input logic sub);
    exp_t r;
    logic [MAG_W-1:0] ma, mb, big, sml, m;
    logic sa, sb_, sbig, ssml, s;
    logic [7:0] ea, eb, e, d;
    ea = a[7:0]; eb = b[7:0];
    ma = MAG_W'(a[63:8]); mb = MAG_W'(b[63:8]);
    sa = a[64]; sb_ = b[64] ^ sub;
    if (ea >= eb) begin d = ea - eb; big = ma; sml = mb; sbig = sa; ssml = sb_; e = ea; end
    else          begin d = eb - ea; big = mb; sml = ma; sbig = sb_; ssml = sa; e = eb; end
    sml = (d >= 8'd14) ? '0 : (sml >> (4 * int'(d)));
    if (sbig == ssml)    begin m = big + sml; s = sbig; end
    else if (big >= sml) begin m = big - sml; s = sbig; end
    else                 begin m = sml - big; s = ssml; end
    if (m == '0) s = 1'b0;
    r.ovf = 1'b0;
    if (m >= (MAG_W'(16) << 52)) begin
      m = m >> 4;
      if (e == 8'hFF) r.ovf = 1'b1;
      else            e = e + 8'd1;
    end
    r.w = {a[67:65], s, m[55:0], e};
    r.cyc = 0;
    r.req = "";
    return r;
  endfunction

  task automatic check(input string req, input logic [WORD_W-1:0] act,
                       input logic [WORD_W-1:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic issue(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                       input logic sub, input string req);
    exp_t e;
    @(negedge clk);
    start = 1'b1; op_sub = sub; opnd_a = a; opnd_b = b;
    e = model(a, b, sub);
    e.cyc = cyc + 3;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
      opnd_a = {WORD_W{1'b1}};
      opnd_b = {WORD_W{1'b1}};
    end
  endtask

  // scoreboard monitor
  logic [WORD_W-1:0] prev_res;
  logic              prev_ovf;
  logic [2:0]        prev_tag;
  always @(negedge clk) begin
    if (run) begin
      if (done) begin
        if (sb.size() == 0) begin
          checks++; failures++;
          $display("FAIL R9 done without pending op actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({e.req, " result"}, result, e.w);
          check({e.req, " R8 tag_out"}, WORD_W'(tag_out), WORD_W'(e.w[67:65]));
          check({e.req, " R5 ovf"}, WORD_W'(ovf), WORD_W'(e.ovf));
          check({e.req, " R9 latency"}, WORD_W'(cyc), WORD_W'(e.cyc));
        end
      end else begin
        check("R11 hold result", result, prev_res);
        check("R11 hold ovf/tag", WORD_W'({prev_ovf, prev_tag}), WORD_W'({ovf, tag_out}));
      end
      prev_res <= result; prev_ovf <= ovf; prev_tag <= tag_out;
    end
  end

  initial begin
    #(200000 * 5);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 result", result, '0);
    check("R10 done/ovf/tag", WORD_W'({done, ovf, tag_out}), '0);
    prev_res = result; prev_ovf = ovf; prev_tag = tag_out;
    run = 1'b1;

    // R1 plain add 1+1 = 2
    issue(mk(3'd1, 0, dig(1, 52), 8'h40), mk(3'd1, 0, dig(1, 52), 8'h40), 0, "R1 add");
    idle(5);
    // R2 alignment cases
    issue(mk(3'd0, 0, dig(1, 52), 8'h41), mk(3'd0, 0, dig(1, 52), 8'h40), 0, "R2 diff1");
    issue(mk(3'd0, 0, dig(1, 52), 8'h40), mk(3'd0, 0, dig(1, 52), 8'h43), 0, "R2 b larger exp");
    issue(mk(3'd0, 0, dig(1, 52), 8'h4D), mk(3'd0, 0, dig(1, 52), 8'h40), 0, "R2 diff13");
    issue(mk(3'd0, 0, dig(1, 52), 8'h4E), mk(3'd0, 0, dig(1, 52), 8'h40), 0, "R2 diff14");
    // R3 leading zeros kept: 1.0 - 0.F = 0.1 hex
    issue(mk(3'd2, 0, dig(1, 52), 8'h40), mk(3'd2, 0, dig(15, 48), 8'h40), 1, "R3 no left shift");
    idle(2);
    // R4 carry with dropped low bit
    issue(mk(3'd0, 0, dig(8, 52) | 56'd1, 8'h20), mk(3'd0, 0, dig(8, 52), 8'h20), 0, "R4 carry");
    // R5 overflow at top exponent
    issue(mk(3'd7, 0, dig(8, 52), 8'hFF), mk(3'd7, 0, dig(8, 52), 8'hFF), 0, "R5 overflow");
    // R6 subtract of a negative
    issue(mk(3'd0, 0, dig(2, 52), 8'h40), mk(3'd0, 1, dig(3, 52), 8'h40), 1, "R6 sub negative");
    // R7 sign handling
    issue(mk(3'd0, 0, dig(2, 52), 8'h40), mk(3'd0, 1, dig(3, 52), 8'h40), 0, "R7 larger negative");
    issue(mk(3'd0, 1, dig(3, 52), 8'h40), mk(3'd0, 0, dig(3, 52), 8'h40), 0, "R7 cancel to +0");
    issue(mk(3'd0, 1, dig(5, 52), 8'h42), mk(3'd0, 1, dig(4, 52), 8'h42), 0, "R7 both negative");
    idle(1);
    // R8 tag from a only
    issue(mk(3'd5, 0, dig(1, 52), 8'h10), mk(3'd2, 0, dig(1, 52), 8'h10), 0, "R8 tag a=5");
    issue(mk(3'd3, 0, dig(1, 52), 8'h10), mk(3'd6, 0, dig(1, 52), 8'h10), 0, "R8 tag a=3");
    issue(mk(3'd3, 0, dig(1, 52), 8'h10), mk(3'd1, 0, dig(1, 52), 8'h10), 0, "R8 tag b changed");
    idle(8);

    // R10 reset mid-stream then idle
    @(negedge clk);
    rst = 1'b1;
    run = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 result after reset", result, '0);
    check("R10 done/ovf/tag after reset", WORD_W'({done, ovf, tag_out}), '0);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R9 pending ops actual=%0d expected=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule